// File: doc/BRIEF.md
# Programmable Waveform State Engine

This block generates the handshake timing for an external bus from a small program that software writes into it. A descriptor store holds four waveforms. Each waveform is a set of up to seven programmable states, S0 to S6, plus a fixed idle state. Each state is a four-byte instruction, and the engine decodes it while it runs. An instruction sets the control pins, each of which can be driven high, driven low or released to high impedance. It can also drive the data bus, capture the data bus, step the address lines, advance the FIFO pointer and raise an interrupt pulse. Finally, it chooses the next state. There are two kinds of state:
- A timed state holds for a programmed number of cycles and then moves on to the next state.
- A decision state combines two selected conditions with AND, OR or XOR and branches to a true target or a false target.

Software loads the descriptors and the configuration through a byte-wide register port. It then pulses a trigger together with a two-bit waveform select. The engine clears its done flag and runs through the states. It sets done again when the program reaches idle, and at that point the pins take their programmed idle levels. The surrounding FIFO storage supplies the outbound data and the FIFO flags. It accepts the capture strobes and the pointer-advance strobes.

Top module: `wfe_engine`

## Requirements
- R1: After reset, done is 1, the engine is idle, ctlOe, busOe and addrOut are 0, and irq, fifoNext and fifoInWr are 0.
- R2: A register write below address 0x80 stores a descriptor byte. The byte for waveform w, state s and field f sits at address 32w+4s+f, where f0 is the length/branch byte, f1 the opcode, f2 the logic byte and f3 the output byte. Configuration registers: 0x80 config (bit0 software ready, bit1 asynchronous ready sampling, bit2 expired replaces ready5, bits5:4 FIFO flag select), 0x81 idle control, 0x82 idle bus (bit0 drive), 0x83 transfer count load, 0x84 single-mode outbound data, 0x85 address load.
- R3: A trigger is accepted only while done is 1. On the next clock, done is 0 and the entry actions of S0 of the selected waveform are on the outputs. A trigger that arrives while done is 0 has no effect.
- R4: A timed state (opcode bit0 = 0) lasts L cycles, where L is the length byte and 0 means 256. It then enters the next state number. Leaving S6 enters idle.
- R5: A decision state (opcode bit0 = 1) evaluates its condition every cycle. Logic byte bits2:0 select operand A and bits5:3 select operand B. Bits7:6 select the function: 1 is OR, 2 is XOR, 0 and 3 are AND. Branch byte bits5:3 give the target when the result is 1, and bits2:0 give the target when it is 0. A target of 7 means idle.
- R6: Condition sources: 0 to 5 are ready pins 0 to 5. Source 6 is the FIFO flag selected by config bits5:4 (0 empty, 1 full, 2 programmable, 3 empty). Source 7 is the software ready bit.
- R7: Ready pins pass through one register stage in synchronous mode and through two stages in asynchronous mode (config bit1).
- R8: On entry to a state, ctlOut takes output-byte bits3:0 and ctlOe takes bits7:4. Both hold until the next entry.
- R9: On entry, the opcode acts as follows:
  - bit2 pulses irq for one cycle.
  - bit3 increments addrOut.
  - bit4 pulses fifoNext, in FIFO mode only (bit1 = 1).
  - bit5 sets busOe, with busOut taken from fifoOutData in FIFO mode and from the single-mode register otherwise.
  - bit6 captures busIn. In FIFO mode it goes to fifoInData with a fifoInWr pulse; otherwise it goes to sglInData.
- R10: When a decision state branches to itself and branch byte bit7 is set, the entry actions are performed again in every cycle of the loop. When bit7 is clear, the state loops without performing them.
- R11: The transfer counter is loaded through register 0x83. It decrements, saturating at 0, on each entry whose opcode drives or captures the bus. Expired is true at 0 and replaces ready5 as source 5 when config bit2 is set.
- R12: On entering idle, done becomes 1, ctlOut and ctlOe take bits3:0 and bits7:4 of the idle control register, busOe takes idle bus bit0, and busOut takes the single-mode data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 8 | Register address |
| regData | input | 8 | Register write data |
| trig | input | 1 | Start request |
| trigWave | input | 2 | Waveform select for the trigger |
| ready | input | 6 | External ready conditions |
| fifoEmpty | input | 1 | FIFO empty flag |
| fifoFull | input | 1 | FIFO full flag |
| fifoProg | input | 1 | FIFO programmable-level flag |
| fifoOutData | input | DATA_W | Outbound FIFO head word |
| busIn | input | DATA_W | Data bus sampled value |
| ctlOut | output | 4 | Control pin levels |
| ctlOe | output | 4 | Control pin enables |
| busOut | output | DATA_W | Data bus drive value |
| busOe | output | 1 | Data bus enable |
| addrOut | output | ADDR_W | Address lines |
| fifoNext | output | 1 | FIFO pointer advance pulse |
| fifoInWr | output | 1 | Inbound FIFO write pulse |
| fifoInData | output | DATA_W | Word captured for the inbound FIFO |
| sglInData | output | DATA_W | Word captured in single mode |
| irq | output | 1 | Per-state interrupt pulse |
| done | output | 1 | Engine idle |

## Verification
The decision logic is driven with all four combinations of two ready pins under each of AND, OR and XOR. This separates a swapped or wrong function from a wrong operand select. The flag and software-ready sources are also tried, to expose a wrong FIFO-flag mux. A ready edge that lands one cycle before the first decision tells the one-stage sampling path from the two-stage one. Self-loops run with and without re-execute, and the address count shows whether actions repeat. A counted loop that exits on the expired substitute, run next to the same loop that exits on a raw ready5 pin, shows whether the counter decrements and whether the source substitution works.

// File: rtl/wfe_pkg.sv
package wfe_pkg;
  // Width of a state number; the all-ones value is the idle state.
  localparam int STATE_W = 3;
  localparam logic [STATE_W-1:0] IDLE_ST = 3'd7;
  // Control pins: one output byte splits into levels and enables.
  localparam int CTL_W = 4;

  // Per-cycle strobes from control to datapath.
  typedef struct packed {
    logic       enter;     // entering a programmable state
    logic       goIdle;    // entering idle
    logic       fifoMode;
    logic       irq;
    logic       incAddr;
    logic       next;
    logic       drive;
    logic       capture;
    logic [7:0] outByte;
  } wfe_strobe_t;
endpackage

// File: rtl/wfe_store.sv
module wfe_store #(
  parameter int DESC_BYTES = 128
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWr,
  input  logic [7:0]  regAddr,
  input  logic [7:0]  regData,
  input  logic [4:0]  rdIdx,
  output logic [31:0] rdInstr,
  output logic        softRdy,
  output logic        asyncRdy,
  output logic        substTc,
  output logic [1:0]  flagSel,
  output logic [7:0]  idleCtl,
  output logic        idleDrive,
  output logic [7:0]  sglOut,
  output logic        tcLoad,
  output logic        addrLoad,
  output logic [7:0]  loadVal
);
  localparam int IDX_W = $clog2(DESC_BYTES);

  logic [7:0] mem [DESC_BYTES];
  logic [7:0] cfgReg;
  logic       idleBusReg;
  logic       descWr;

  assign descWr = regWr && !regAddr[7];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DESC_BYTES; i++) mem[i] <= '0;
      cfgReg     <= '0;
      idleCtl    <= '0;
      idleBusReg <= 1'b0;
      sglOut     <= '0;
    end else if (regWr) begin
      if (descWr) mem[regAddr[IDX_W-1:0]] <= regData;
      case (regAddr)
        8'h80:   cfgReg     <= regData;
        8'h81:   idleCtl    <= regData;
        8'h82:   idleBusReg <= regData[0];
        8'h84:   sglOut     <= regData;
        default: ;
      endcase
    end
  end

  // Four field bytes of the addressed state, little-end first.
  for (genvar f = 0; f < 4; f++) begin : g_rd
    assign rdInstr[8*f +: 8] = mem[{rdIdx, 2'(f)}];
  end

  assign softRdy   = cfgReg[0];
  assign asyncRdy  = cfgReg[1];
  assign substTc   = cfgReg[2];
  assign flagSel   = cfgReg[5:4];
  assign idleDrive = idleBusReg;
  assign tcLoad    = regWr && (regAddr == 8'h83);
  assign addrLoad  = regWr && (regAddr == 8'h85);
  assign loadVal   = regData;
endmodule

// File: rtl/wfe_ctrl.sv
module wfe_ctrl
  import wfe_pkg::*;
#(
  parameter int RDY_N = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              trig,
  input  logic [1:0]        trigWave,
  input  logic [RDY_N-1:0]  ready,
  input  logic              fifoEmpty,
  input  logic              fifoFull,
  input  logic              fifoProg,
  input  logic              softRdy,
  input  logic              asyncRdy,
  input  logic              substTc,
  input  logic [1:0]        flagSel,
  input  logic              expired,
  input  logic [31:0]       rdInstr,
  output logic [4:0]        rdIdx,
  output wfe_strobe_t       stb,
  output logic              done
);
  logic [STATE_W-1:0] curSt, nextSt;
  logic [1:0]         waveSel;
  logic [8:0]         holdCnt;
  logic [7:0]         curLen, curLogic;
  logic               curDec;
  logic               advance;
  logic [RDY_N-1:0]   rdyA, rdyB, rdySeen;
  logic [7:0]         cond;
  logic               flagBit, opA, opB, result;

  // Ready sampling: one stage, or two for asynchronous sources.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdyA <= '0;
      rdyB <= '0;
    end else begin
      rdyA <= ready;
      rdyB <= rdyA;
    end
  end
  assign rdySeen = asyncRdy ? rdyB : rdyA;

  always_comb begin
    case (flagSel)
      2'd1:    flagBit = fifoFull;
      2'd2:    flagBit = fifoProg;
      default: flagBit = fifoEmpty;
    endcase
  end

  assign cond = {softRdy, flagBit, (substTc ? expired : rdySeen[5]), rdySeen[4:0]};
  assign opA  = cond[curLogic[2:0]];
  assign opB  = cond[curLogic[5:3]];

  always_comb begin
    case (curLogic[7:6])
      2'd1:    result = opA | opB;
      2'd2:    result = opA ^ opB;
      default: result = opA & opB;
    endcase
  end

  always_comb begin
    advance = 1'b0;
    nextSt  = curSt;
    if (done) begin
      if (trig) begin
        advance = 1'b1;
        nextSt  = '0;
      end
    end else if (curDec) begin
      nextSt = result ? curLen[5:3] : curLen[2:0];
      if (nextSt != curSt || curLen[7]) advance = 1'b1;
    end else if (holdCnt == 9'd1) begin
      advance = 1'b1;
      nextSt  = curSt + 3'd1;
    end
  end

  assign rdIdx = {(done ? trigWave : waveSel), nextSt};

  always_comb begin
    stb          = '0;
    stb.enter    = advance && (nextSt != IDLE_ST);
    stb.goIdle   = advance && (nextSt == IDLE_ST);
    stb.fifoMode = rdInstr[9];
    stb.irq      = rdInstr[10];
    stb.incAddr  = rdInstr[11];
    stb.next     = rdInstr[12];
    stb.drive    = rdInstr[13];
    stb.capture  = rdInstr[14];
    stb.outByte  = rdInstr[31:24];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      curSt    <= IDLE_ST;
      done     <= 1'b1;
      waveSel  <= '0;
      holdCnt  <= '0;
      curLen   <= '0;
      curLogic <= '0;
      curDec   <= 1'b0;
    end else if (advance) begin
      curSt <= nextSt;
      if (done) waveSel <= trigWave;
      if (nextSt == IDLE_ST) begin
        done <= 1'b1;
      end else begin
        done     <= 1'b0;
        curLen   <= rdInstr[7:0];
        curDec   <= rdInstr[8];
        curLogic <= rdInstr[23:16];
        holdCnt  <= {(rdInstr[7:0] == 8'd0), rdInstr[7:0]};
      end
    end else if (!done && !curDec) begin
      holdCnt <= holdCnt - 9'd1;
    end
  end
endmodule

// File: rtl/wfe_dpath.sv
module wfe_dpath
  import wfe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int TC_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  wfe_strobe_t       stb,
  input  logic [7:0]        idleCtl,
  input  logic              idleDrive,
  input  logic [7:0]        sglOut,
  input  logic              tcLoad,
  input  logic              addrLoad,
  input  logic [7:0]        loadVal,
  input  logic [DATA_W-1:0] fifoOutData,
  input  logic [DATA_W-1:0] busIn,
  output logic [CTL_W-1:0]  ctlOut,
  output logic [CTL_W-1:0]  ctlOe,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [ADDR_W-1:0] addrOut,
  output logic              fifoNext,
  output logic              fifoInWr,
  output logic [DATA_W-1:0] fifoInData,
  output logic [DATA_W-1:0] sglInData,
  output logic              irq,
  output logic              expired
);
  logic [TC_W-1:0] tcCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlOut     <= '0;
      ctlOe      <= '0;
      busOut     <= '0;
      busOe      <= 1'b0;
      fifoNext   <= 1'b0;
      fifoInWr   <= 1'b0;
      fifoInData <= '0;
      sglInData  <= '0;
      irq        <= 1'b0;
    end else begin
      irq      <= 1'b0;
      fifoNext <= 1'b0;
      fifoInWr <= 1'b0;
      if (stb.enter) begin
        ctlOut   <= stb.outByte[CTL_W-1:0];
        ctlOe    <= stb.outByte[2*CTL_W-1:CTL_W];
        irq      <= stb.irq;
        fifoNext <= stb.next && stb.fifoMode;
        busOe    <= stb.drive;
        busOut   <= stb.fifoMode ? fifoOutData : DATA_W'(sglOut);
        if (stb.capture) begin
          if (stb.fifoMode) begin
            fifoInData <= busIn;
            fifoInWr   <= 1'b1;
          end else begin
            sglInData  <= busIn;
          end
        end
      end else if (stb.goIdle) begin
        ctlOut <= idleCtl[CTL_W-1:0];
        ctlOe  <= idleCtl[2*CTL_W-1:CTL_W];
        busOe  <= idleDrive;
        busOut <= DATA_W'(sglOut);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrOut <= '0;
      tcCnt   <= '0;
    end else begin
      if (addrLoad) addrOut <= ADDR_W'(loadVal);
      else if (stb.enter && stb.incAddr) addrOut <= addrOut + 1'b1;
      if (tcLoad) tcCnt <= TC_W'(loadVal);
      else if (stb.enter && (stb.drive || stb.capture) && tcCnt != '0) tcCnt <= tcCnt - 1'b1;
    end
  end

  assign expired = (tcCnt == '0);
endmodule

// File: rtl/wfe_engine.sv
module wfe_engine
  import wfe_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int ADDR_W = 8,
  parameter int TC_W   = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [7:0]        regAddr,
  input  logic [7:0]        regData,
  input  logic              trig,
  input  logic [1:0]        trigWave,
  input  logic [5:0]        ready,
  input  logic              fifoEmpty,
  input  logic              fifoFull,
  input  logic              fifoProg,
  input  logic [DATA_W-1:0] fifoOutData,
  input  logic [DATA_W-1:0] busIn,
  output logic [3:0]        ctlOut,
  output logic [3:0]        ctlOe,
  output logic [DATA_W-1:0] busOut,
  output logic              busOe,
  output logic [ADDR_W-1:0] addrOut,
  output logic              fifoNext,
  output logic              fifoInWr,
  output logic [DATA_W-1:0] fifoInData,
  output logic [DATA_W-1:0] sglInData,
  output logic              irq,
  output logic              done
);
  wfe_strobe_t stb;
  logic [4:0]  rdIdx;
  logic [31:0] rdInstr;
  logic        softRdy, asyncRdy, substTc, idleDrive, tcLoad, addrLoad, expired;
  logic [1:0]  flagSel;
  logic [7:0]  idleCtl, sglOut, loadVal;

  wfe_store u_store (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regData(regData),
    .rdIdx(rdIdx), .rdInstr(rdInstr), .softRdy(softRdy), .asyncRdy(asyncRdy),
    .substTc(substTc), .flagSel(flagSel), .idleCtl(idleCtl), .idleDrive(idleDrive),
    .sglOut(sglOut), .tcLoad(tcLoad), .addrLoad(addrLoad), .loadVal(loadVal)
  );

  wfe_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .trig(trig), .trigWave(trigWave), .ready(ready),
    .fifoEmpty(fifoEmpty), .fifoFull(fifoFull), .fifoProg(fifoProg),
    .softRdy(softRdy), .asyncRdy(asyncRdy), .substTc(substTc), .flagSel(flagSel),
    .expired(expired), .rdInstr(rdInstr), .rdIdx(rdIdx), .stb(stb), .done(done)
  );

  wfe_dpath #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .TC_W(TC_W)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .idleCtl(idleCtl), .idleDrive(idleDrive),
    .sglOut(sglOut), .tcLoad(tcLoad), .addrLoad(addrLoad), .loadVal(loadVal),
    .fifoOutData(fifoOutData), .busIn(busIn), .ctlOut(ctlOut), .ctlOe(ctlOe),
    .busOut(busOut), .busOe(busOe), .addrOut(addrOut), .fifoNext(fifoNext),
    .fifoInWr(fifoInWr), .fifoInData(fifoInData), .sglInData(sglInData),
    .irq(irq), .expired(expired)
  );
endmodule

// File: rtl/wfe_checker.sv
module wfe_checker #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              trig,
  input logic              done,
  input logic              irq,
  input logic              fifoNext,
  input logic              fifoInWr,
  input logic              regWr,
  input logic [7:0]        regAddr,
  input logic [ADDR_W-1:0] addrOut,
  input logic [3:0]        ctlOut,
  input logic [3:0]        ctlOe,
  input logic [7:0]        idleCtl
);
  // R3: an accepted trigger starts a run on the next edge
  p_trig_start_r3: assert property (@(posedge clk) disable iff (!rstN)
    (done && trig) |=> !done);

  // R3: idle persists until a trigger arrives
  p_done_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (done && !trig) |=> done);

  // R9: interrupt pulses only come from programmable states
  p_irq_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !done);

  // R9: FIFO strobes only while a waveform runs
  p_strobe_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (fifoNext || fifoInWr) |-> !done);

  // R9: address moves by one step or by a register load
  p_addr_step_r9: assert property (@(posedge clk) disable iff (!rstN)
    (addrOut != $past(addrOut)) |->
      ((addrOut == $past(addrOut) + 1'b1) || $past(regWr && regAddr == 8'h85)));

  // R12: entering idle applies the idle control register
  p_idle_ctl_r12: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> (ctlOut == $past(idleCtl[3:0]) && ctlOe == $past(idleCtl[7:4])));
endmodule

bind wfe_engine wfe_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .trig(trig), .done(done), .irq(irq),
  .fifoNext(fifoNext), .fifoInWr(fifoInWr), .regWr(regWr), .regAddr(regAddr),
  .addrOut(addrOut), .ctlOut(ctlOut), .ctlOe(ctlOe), .idleCtl(idleCtl)
);

// File: tb/wfe_engine_tb.sv
`timescale 1ns/1ps
module wfe_engine_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWr = 1'b0;
  logic [7:0] regAddr = '0, regData = '0;
  logic       trig = 1'b0;
  logic [1:0] trigWave = '0;
  logic [5:0] ready = '0;
  logic       fifoEmpty = 1'b0, fifoFull = 1'b0, fifoProg = 1'b0;
  logic [7:0] fifoOutData = '0, busIn = '0;
  logic [3:0] ctlOut, ctlOe;
  logic [7:0] busOut, addrOut, fifoInData, sglInData;
  logic       busOe, fifoNext, fifoInWr, irq, done;

  int vecs = 0;
  int errs = 0;
  bit finished = 0;

  wfe_engine u_dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regData(regData),
    .trig(trig), .trigWave(trigWave), .ready(ready), .fifoEmpty(fifoEmpty),
    .fifoFull(fifoFull), .fifoProg(fifoProg), .fifoOutData(fifoOutData), .busIn(busIn),
    .ctlOut(ctlOut), .ctlOe(ctlOe), .busOut(busOut), .busOe(busOe), .addrOut(addrOut),
    .fifoNext(fifoNext), .fifoInWr(fifoInWr), .fifoInData(fifoInData),
    .sglInData(sglInData), .irq(irq), .done(done)
  );

  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    regWr = 1'b1; regAddr = a; regData = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  // R2: field f of state s of waveform w lives at 32w+4s+f
  task automatic putState(input int w, input int s, input logic [7:0] lb,
                          input logic [7:0] opc, input logic [7:0] lg, input logic [7:0] ob);
    wr(8'(32*w + 4*s + 0), lb);
    wr(8'(32*w + 4*s + 1), opc);
    wr(8'(32*w + 4*s + 2), lg);
    wr(8'(32*w + 4*s + 3), ob);
  endtask

  task automatic fire(input logic [1:0] w);
    trig = 1'b1; trigWave = w;
    @(negedge clk);
    trig = 1'b0;
  endtask

  task automatic waitDone();
    for (int i = 0; i < 600 && !done; i++) @(negedge clk);
    chk("R5 run reaches idle", done, 1);
  endtask

  task automatic idleLoop(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 done", done, 1);
    chk("R1 ctlOe", ctlOe, 0);
    chk("R1 busOe", busOe, 0);
    chk("R1 addr", addrOut, 0);
    chk("R1 strobes", {irq, fifoNext, fifoInWr}, 0);
  endtask

  task automatic t_sequence();
    putState(0, 0, 8'd3, 8'h08, 8'h00, 8'hF5);
    putState(0, 1, 8'd1, 8'h04, 8'h00, 8'hFA);
    putState(0, 2, 8'h3F, 8'h01, 8'h00, 8'hF3);
    wr(8'h81, 8'h59); wr(8'h82, 8'h01); wr(8'h84, 8'hA7); wr(8'h85, 8'h10);
    fire(2'd0);
    chk("R3 done cleared", done, 0);
    chk("R2 R8 S0 ctl", {ctlOe, ctlOut}, 8'hF5);
    chk("R9 addr inc", addrOut, 8'h11);
    idleLoop(2);
    chk("R4 still S0 after 3rd cycle", ctlOut, 4'h5);
    idleLoop(1);
    chk("R4 S1 after 3 cycles", ctlOut, 4'hA);
    chk("R9 irq pulse", irq, 1);
    idleLoop(1);
    chk("R9 irq one cycle", irq, 0);
    chk("R8 S2 ctl", ctlOut, 4'h3);
    idleLoop(1);
    chk("R12 done", done, 1);
    chk("R12 idle ctl", {ctlOe, ctlOut}, 8'h59);
    chk("R12 idle bus", {busOe, busOut}, {1'b1, 8'hA7});
  endtask

  task automatic t_long();
    int n = 0;
    putState(0, 0, 8'd0, 8'h00, 8'h00, 8'hF1);
    putState(0, 1, 8'h3F, 8'h01, 8'h00, 8'hF2);
    fire(2'd0);
    while (ctlOut == 4'h1 && n < 400) begin
      n++;
      if (n == 100) begin trig = 1'b1; trigWave = 2'd1; end
      else trig = 1'b0;
      @(negedge clk);
    end
    trig = 1'b0;
    chk("R4 length 0 gives 256", n, 256);
    chk("R3 busy trigger ignored", ctlOut, 4'h2);
    waitDone();
  endtask

  // wave 1: S0 decision, true -> S5 (ctl 5), false -> S6 (ctl 6)
  task automatic decide(input string tag, input logic [7:0] lg, input logic [3:0] exp);
    wr(8'(32 + 2), lg);
    idleLoop(3);
    fire(2'd1);
    idleLoop(1);
    chk(tag, ctlOut, exp);
    waitDone();
  endtask

  task automatic t_decision();
    putState(1, 0, 8'h2E, 8'h01, 8'h00, 8'hF0);
    putState(1, 5, 8'd1, 8'h00, 8'h00, 8'hF5);
    putState(1, 6, 8'd1, 8'h00, 8'h00, 8'hF6);
    wr(8'h80, 8'h00);
    for (int f = 0; f < 3; f++) begin
      for (int c = 0; c < 4; c++) begin
        logic a, b, r;
        a = c[0]; b = c[1];
        r = (f == 1) ? (a | b) : (f == 2) ? (a ^ b) : (a & b);
        ready = {4'b0, b, a};
        decide("R5 function/operands", {2'(f), 3'd1, 3'd0}, r ? 4'h5 : 4'h6);
      end
    end
    ready = '0;
    fifoFull = 1'b1; fifoEmpty = 1'b0;
    wr(8'h80, 8'h10);
    decide("R6 full flag selected", {2'd0, 3'd6, 3'd6}, 4'h5);
    wr(8'h80, 8'h00);
    decide("R6 empty flag selected", {2'd0, 3'd6, 3'd6}, 4'h6);
    fifoFull = 1'b0;
    wr(8'h80, 8'h01);
    decide("R6 software ready", {2'd1, 3'd7, 3'd0}, 4'h5);
  endtask

  task automatic t_async(input logic asyncOn, input logic [3:0] exp);
    wr(8'h80, {6'b0, asyncOn, 1'b0});
    wr(8'(32 + 2), 8'h00);
    ready = '0;
    idleLoop(4);
    ready[0] = 1'b1;
    fire(2'd1);
    idleLoop(1);
    chk(asyncOn ? "R7 async extra stage" : "R7 sync one stage", ctlOut, exp);
    waitDone();
    ready = '0;
  endtask

  task automatic t_reexec(input logic rex);
    putState(2, 0, {rex, 7'b0000110}, 8'h09, {2'd0, 3'd7, 3'd7}, 8'hF0);
    putState(2, 6, 8'd1, 8'h00, 8'h00, 8'hF6);
    wr(8'h85, 8'h00);
    wr(8'h80, 8'h01);
    fire(2'd2);
    idleLoop(4);
    chk(rex ? "R10 re-execute repeats" : "R10 loop without repeat", addrOut, rex ? 8'd5 : 8'd1);
    wr(8'h80, 8'h00);
    waitDone();
    chk("R10 final address", addrOut, rex ? 8'd6 : 8'd1);
  endtask

  task automatic t_count(input logic subst, input int exp);
    int pulses = 0;
    int bad = 0;
    putState(3, 0, 8'd1, 8'h32, 8'h00, 8'hF1);
    putState(3, 1, 8'h38, 8'h01, {2'd0, 3'd5, 3'd5}, 8'hF2);
    fifoOutData = 8'h3C;
    ready[5] = !subst;
    wr(8'h80, {5'b0, subst, 2'b0});
    wr(8'h83, 8'd3);
    idleLoop(3);
    fire(2'd3);
    for (int i = 0; i < 50 && !done; i++) begin
      if (fifoNext) pulses++;
      if (busOe && busOut != 8'h3C) bad++;
      @(negedge clk);
    end
    chk(subst ? "R11 expired exits after count" : "R11 raw ready5 exits", pulses, exp);
    chk("R9 drive from fifo", bad, 0);
    chk("R11 ends idle", done, 1);
    ready = '0;
  endtask

  task automatic t_capture();
    putState(3, 0, 8'd1, 8'h42, 8'h00, 8'hF1);
    putState(3, 1, 8'd1, 8'h40, 8'h00, 8'hF2);
    putState(3, 2, 8'h3F, 8'h01, 8'h00, 8'hF3);
    wr(8'h80, 8'h00);
    busIn = 8'h81;
    fire(2'd3);
    chk("R9 fifo capture strobe", fifoInWr, 1);
    chk("R9 fifo capture data", fifoInData, 8'h81);
    busIn = 8'h42;
    idleLoop(1);
    chk("R9 single capture data", sglInData, 8'h42);
    chk("R9 single no strobe", {fifoInWr, fifoInData}, {1'b0, 8'h81});
    waitDone();
  endtask

  initial begin
    #(5.0 * 150000);
    errs++;
    $display("FAIL R3 watchdog actual=running expected=finished");
    if (!finished) begin
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    idleLoop(3);
    rstN = 1'b1;
    idleLoop(1);
    t_reset();
    t_sequence();
    t_long();
    t_decision();
    t_async(1'b0, 4'h5);
    t_async(1'b1, 4'h6);
    t_reexec(1'b1);
    t_reexec(1'b0);
    t_count(1'b1, 3);
    t_count(1'b0, 1);
    t_capture();
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule